// File: doc/BRIEF.md
# UART host register interface

This block is the bus-facing register file of a 16550-style UART. The serial engine sits behind it on a simple byte interface. The host selects one of eight byte registers with a three-bit word index, taken from byte-address bits 4 to 2. A received byte arrives from the line side with a one-cycle valid strobe. The block latches the byte, reports it in the line status and raises a receive interrupt request. A host write to the transmit holding register comes out on the line side as a byte with a one-cycle strobe.

Reads are combinational: `rdata_o` follows `addr_i` in the same cycle. Side effects take place on the clock edge where `req_i` is high. Reading the receive buffer returns the held byte and, on that same edge, clears data-ready and drops the interrupt request. The host therefore never sees a stale pending state. While an interrupt is pending, the block refuses any further incoming byte, so the held byte cannot be overwritten before it is read. Serial bit timing, divisor latches, FIFOs and modem signalling are not part of this block.

Top module: `uart_regif`

## Requirements
- R1: After reset, index 5 (line status) reads 0x60, index 2 (interrupt identification) reads 0x01, `irq_o` is 0 and `tx_valid_o` is 0.
- R2: The register index decodes as follows. Index 0 is the receive buffer on read and transmit holding on write. Index 1 is interrupt enable. Index 2 is interrupt identification on read and FIFO control on write. Index 5 is line status, index 6 is modem status and index 7 is scratch.
- R3: A byte with `rx_valid_i` high and no pending interrupt is latched on that edge. From the next cycle, index 0 reads the byte, line status bit 0 is 1, `irq_o` is 1 and index 2 reads 0x04.
- R4: While `irq_o` is 1, a strobed byte is ignored, and index 0 keeps returning the first byte.
- R5: A read of index 0 returns the held byte in the cycle of the access. From the next cycle, line status bit 0 is 0, `irq_o` is 0 and index 2 reads 0x01. A byte strobed in the same cycle as that read is dropped.
- R6: A write to index 0 makes `tx_valid_o` 1 for exactly the next cycle, with `tx_data_o` equal to the written byte. Line status bit 5 is 1 afterwards.
- R7: Index 7 returns the last value written to it, and writing it changes no other register.
- R8: Index 1 returns the last value written to it. A write to index 2 changes no readable register.
- R9: Indices 3 and 4 read the same value as line status. Index 6 reads 0.
- R10: Reads of any index other than 0 leave data-ready and `irq_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register index (byte-address bits 4:2) |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, combinational on addr_i |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_data_o | output | 8 | Transmit byte |
| irq_o | output | 1 | Receive interrupt request |

## Verification
Read data is combinational, so the bench samples `rdata_o` mid-cycle during the access itself. Every stateful result lands on the edge that ends an access or a receive strobe: data-ready, `irq_o`, the stored registers and the transmit strobe. The bench reads these at the next falling edge, one register stage later. The transmit strobe is also sampled one cycle after that, to confirm it lasts exactly one cycle. For the dropped-byte cases, the bench reads the receive buffer back through the host port after the ignored strobe and before any further stimulus.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned IDX_LSB = 2;
  localparam int unsigned DW      = 8;

  localparam logic [IDX_W-1:0] IDX_DATA = 3'd0;
  localparam logic [IDX_W-1:0] IDX_IEN  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_IID  = 3'd2;
  localparam logic [IDX_W-1:0] IDX_AL3  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_AL4  = 3'd4;
  localparam logic [IDX_W-1:0] IDX_LST  = 3'd5;
  localparam logic [IDX_W-1:0] IDX_MST  = 3'd6;
  localparam logic [IDX_W-1:0] IDX_SCR  = 3'd7;

  localparam logic [DW-1:0] IID_NONE = 8'h01;
  localparam logic [DW-1:0] IID_RXDA = 8'h04;

  function automatic logic [DW-1:0] pack_lsr(input logic dr, input logic thre);
    logic [DW-1:0] v;
    v    = '0;
    v[0] = dr;
    v[5] = thre;
    v[6] = 1'b1;  // transmitter idle: no serial engine behind us
    return v;
  endfunction
endpackage

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_regif_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rd_data_i,
  output logic [DW-1:0] rbr_o,
  output logic          dr_o,
  output logic          irq_o
);
  logic accept;
  // incoming byte refused while a previous one is still pending
  assign accept = rx_valid_i & ~irq_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbr_o <= '0;
      dr_o  <= 1'b0;
      irq_o <= 1'b0;
    end else if (rd_data_i) begin
      dr_o  <= 1'b0;
      irq_o <= 1'b0;
    end else if (accept) begin
      rbr_o <= rx_data_i;
      dr_o  <= 1'b1;
      irq_o <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
  import uart_regif_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  output logic          thre_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
      thre_o     <= 1'b1;
    end else begin
      tx_valid_o <= wr_i;
      if (wr_i) begin
        tx_data_o <= wdata_i;
        thre_o    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rd_mux.sv
module uart_rd_mux
  import uart_regif_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    rbr_i,
  input  logic [DW-1:0]    ier_i,
  input  logic [DW-1:0]    scr_i,
  input  logic             dr_i,
  input  logic             thre_i,
  input  logic             irq_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] lsr;
  assign lsr = pack_lsr(dr_i, thre_i);

  always_comb begin
    unique case (idx_i)
      IDX_DATA: rdata_o = rbr_i;
      IDX_IEN:  rdata_o = ier_i;
      IDX_IID:  rdata_o = irq_i ? IID_RXDA : IID_NONE;
      IDX_AL3,
      IDX_AL4,
      IDX_LST:  rdata_o = lsr;
      IDX_SCR:  rdata_o = scr_i;
      default:  rdata_o = '0;  // modem status: no modem lines
    endcase
  end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [IDX_LSB+IDX_W-1:IDX_LSB] addr_i,
  input  logic [DW-1:0]                wdata_i,
  output logic [DW-1:0]                rdata_o,
  input  logic                         rx_valid_i,
  input  logic [DW-1:0]                rx_data_i,
  output logic                         tx_valid_o,
  output logic [DW-1:0]                tx_data_o,
  output logic                         irq_o
);
  logic [IDX_W-1:0] idx;
  logic             rd_data, wr_data, wr_ien, wr_scr;
  logic [DW-1:0]    rbr_q, ier_q, scr_q;
  logic             dr_q, thre_q;

  assign idx     = addr_i;
  assign rd_data = req_i & ~we_i & (idx == IDX_DATA);
  assign wr_data = req_i &  we_i & (idx == IDX_DATA);
  assign wr_ien  = req_i &  we_i & (idx == IDX_IEN);
  assign wr_scr  = req_i &  we_i & (idx == IDX_SCR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_q <= '0;
      scr_q <= '0;
    end else begin
      if (wr_ien) ier_q <= wdata_i;
      if (wr_scr) scr_q <= wdata_i;
    end
  end

  uart_rx_hold u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .rd_data_i  (rd_data),
    .rbr_o      (rbr_q),
    .dr_o       (dr_q),
    .irq_o      (irq_o)
  );

  uart_tx_hold u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_data),
    .wdata_i    (wdata_i),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .thre_o     (thre_q)
  );

  uart_rd_mux u_mux (
    .idx_i   (idx),
    .rbr_i   (rbr_q),
    .ier_i   (ier_q),
    .scr_i   (scr_q),
    .dr_i    (dr_q),
    .thre_i  (thre_q),
    .irq_i   (irq_o),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk
  import uart_regif_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_data,
  input logic          wr_data,
  input logic          req_i,
  input logic          we_i,
  input logic [DW-1:0] wdata_i,
  input logic          rx_valid_i,
  input logic [DW-1:0] rbr_q,
  input logic          dr_q,
  input logic          irq_o,
  input logic          tx_valid_o,
  input logic [DW-1:0] tx_data_o
);
  p_irq_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(rx_valid_i));

  p_dr_irq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dr_q == irq_o);

  p_rx_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rd_data) |=> (irq_o && $stable(rbr_q)));

  p_rd_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data |=> (!irq_o && !dr_q));

  p_tx_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data |=> (tx_valid_o && tx_data_o == $past(wdata_i)));

  p_tx_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_data |=> !tx_valid_o);

  p_other_rd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !rd_data && !rx_valid_i) |=> $stable(irq_o));
endmodule

bind uart_regif uart_regif_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_data    (rd_data),
  .wr_data    (wr_data),
  .req_i      (req_i),
  .we_i       (we_i),
  .wdata_i    (wdata_i),
  .rx_valid_i (rx_valid_i),
  .rbr_q      (rbr_q),
  .dr_q       (dr_q),
  .irq_o      (irq_o),
  .tx_valid_o (tx_valid_o),
  .tx_data_o  (tx_data_o)
);

// File: tb/uart_regif_tb.sv
module uart_regif_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0, we_i = 1'b0;
  logic [4:2] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       tx_valid_o, irq_o;
  logic [7:0] tx_data_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  uart_regif u_dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [2:0] idx, logic [7:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = idx; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(logic [2:0] idx, output logic [7:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = idx;
    #1 d = rdata_o;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic rx_push(logic [7:0] b);
    @(negedge clk_i);
    rx_valid_i = 1'b1; rx_data_i = b;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    chk("R1 txv", {7'd0, tx_valid_o}, 8'h00);
    bus_rd(3'd5, v); chk("R1 lsr", v, 8'h60);
    bus_rd(3'd2, v); chk("R1 iir", v, 8'h01);
  endtask

  task automatic t_storage;
    logic [7:0] v;
    bus_wr(3'd7, 8'hA5);
    bus_rd(3'd7, v); chk("R7 scr", v, 8'hA5);
    bus_rd(3'd1, v); chk("R7 ier untouched", v, 8'h00);
    bus_wr(3'd1, 8'h0F);
    bus_rd(3'd1, v); chk("R8 ier", v, 8'h0F);
    bus_wr(3'd2, 8'hC7);
    bus_rd(3'd2, v); chk("R8 fcr no effect iir", v, 8'h01);
    bus_rd(3'd7, v); chk("R8 fcr no effect scr", v, 8'hA5);
    bus_rd(3'd5, v); chk("R8 fcr no effect lsr", v, 8'h60);
    bus_rd(3'd6, v); chk("R9 msr", v, 8'h00);
  endtask

  task automatic t_rx;
    logic [7:0] v;
    rx_push(8'h3C);
    chk("R3 irq", {7'd0, irq_o}, 8'h01);
    bus_rd(3'd5, v); chk("R3 lsr", v, 8'h61);
    bus_rd(3'd2, v); chk("R3 iir", v, 8'h04);
    bus_rd(3'd3, v); chk("R9 idx3", v, 8'h61);
    bus_rd(3'd4, v); chk("R9 idx4", v, 8'h61);
    bus_rd(3'd7, v);
    chk("R10 irq kept", {7'd0, irq_o}, 8'h01);
    rx_push(8'hC3);
    bus_rd(3'd0, v); chk("R4 first byte kept", v, 8'h3C);
    chk("R5 irq clear", {7'd0, irq_o}, 8'h00);
    bus_rd(3'd5, v); chk("R5 lsr", v, 8'h60);
    bus_rd(3'd2, v); chk("R5 iir", v, 8'h01);
  endtask

  task automatic t_rx_race;
    logic [7:0] v;
    rx_push(8'h11);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = 3'd0;
    rx_valid_i = 1'b1; rx_data_i = 8'h22;
    #1 v = rdata_o;
    chk("R5 read during race", v, 8'h11);
    @(negedge clk_i);
    req_i = 1'b0; rx_valid_i = 1'b0;
    chk("R5 race irq", {7'd0, irq_o}, 8'h00);
    bus_rd(3'd0, v); chk("R5 race byte dropped", v, 8'h11);
    rx_push(8'h5A);
    bus_rd(3'd0, v); chk("R3 second byte", v, 8'h5A);
  endtask

  task automatic t_tx;
    logic [7:0] v;
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = 3'd0; wdata_i = 8'h96;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    chk("R6 txv", {7'd0, tx_valid_o}, 8'h01);
    chk("R6 txd", tx_data_o, 8'h96);
    @(negedge clk_i);
    chk("R6 txv one cycle", {7'd0, tx_valid_o}, 8'h00);
    bus_rd(3'd5, v); chk("R6 lsr", v, 8'h60);
    bus_rd(3'd0, v); chk("R2 thr write leaves rbr", v, 8'h5A);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset;
        t_storage;
        t_rx;
        t_rx_race;
        t_tx;
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk_i);
        if (!done) begin
          n_chk++; n_bad++;
          $display("FAIL watchdog act=hung exp=done");
        end
      end
    join_any
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule